// File: doc/BRIEF.md
# Four-Port Tagged Calculator with Split Execution Pipelines

The block serves four independent command ports. Each port may keep up to four commands in flight, and each command carries a 2-bit tag that the port chooses. The tag comes back with the response. Add, subtract and any unrecognised opcode go to an arithmetic queue. Shift-left and shift-right go to a separate shift queue. Each queue is shared by all four ports and is fed by its own round-robin arbiter, which accepts at most one command per cycle.

The arithmetic pipeline has one compute stage. The shift pipeline has two. Each response is returned on the port that issued the command, with that command's tag. Responses from one pipeline leave in the order they were accepted. Responses from the two pipelines may overtake each other.

A port stalls through its `cmd_ready` output in these cases:
- the tag it presents is still outstanding;
- the target queue is full;
- the arbiter grants another port that cycle.

The host keeps its command stable until it sees `cmd_ready` high.

Top module: `calc_tagged_hub`

## Requirements
- R1: After reset no response is valid, and every tag on every port is free, so a lone command is accepted in the first cycle it is presented.
- R2: Opcode 4'h1 (add) returns the low 32 bits of a+b. The response code is 2'b01 (ok) when the unsigned sum fits in 32 bits and 2'b10 (overflow) when it carries out; a sum of exactly FFFFFFFF is ok.
- R3: Opcode 4'h2 (subtract) returns a-b modulo 2^32. The code is 2'b10 (underflow) when b exceeds a; otherwise it is 2'b01, and equal operands give zero.
- R4: Opcode 4'h5 shifts a left and opcode 4'h6 shifts a right (logical) by b[4:0]; the upper bits of b are ignored, and the code is 2'b01.
- R5: Any other opcode is answered with code 2'b11 (invalid), data zero and the command's own tag; a valid response never carries code 2'b00.
- R6: Every command produces exactly one response, on the issuing port and with the issuing tag; no response appears for a tag that is not outstanding on that port.
- R7: A port may have four commands with distinct tags outstanding, all accepted back-to-back. A command whose tag is still outstanding on that port is held with `cmd_ready` low until that tag's response has been delivered, and `cmd_ready` is never high without `cmd_valid`.
- R8: The responses a port receives from one pipeline arrive in the order that port's commands were accepted.
- R9: Each queue accepts at most one command per cycle. When all four ports request the same queue at once, each is granted in a distinct cycle, within four consecutive cycles.
- R10: When both pipelines finish commands for the same port in the same cycle, the arithmetic response is delivered first and the shift response follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 4 | Per-port command present |
| cmd_op | input | 4x4 | Per-port opcode |
| cmd_tag | input | 4x2 | Per-port command tag |
| cmd_a | input | 4x32 | Per-port first operand |
| cmd_b | input | 4x32 | Per-port second operand (shift amount in bits 4:0) |
| cmd_ready | output | 4 | Per-port command accepted this cycle |
| rsp_valid | output | 4 | Per-port response present for one cycle |
| rsp_code | output | 4x2 | Per-port response code: 01 ok, 10 overflow/underflow, 11 invalid |
| rsp_tag | output | 4x2 | Tag of the command being answered |
| rsp_data | output | 4x32 | Result data |

## Verification
The bench targets the arithmetic edges:
- Sums that land exactly on FFFFFFFF or carry out by one. A design with an off-by-one carry test flags the wrong one of these.
- Subtractions of equal operands and of a+1 from a. A wrong borrow test marks zero as underflow or misses the wrap.
- Shifts by 0 and by 31, and an amount with upper bits set. A design that uses the whole operand as the amount returns zero instead of the truncated shift.

It also reuses a tag at once after issuing it. A design that does not track busy tags accepts the reuse, and the two responses become indistinguishable.

It times a shift followed directly by an add on one port so that both finish in the same cycle. A design without merge priority either drops one of the two responses or delivers the shift first.

// File: rtl/calc_pkg.sv
// Shared constants, request/response records and the two compute functions
// used by the tagged calculator. Assumes four ports and 32-bit data.
package calc_pkg;
    localparam int CALC_PORTS = 4;
    localparam int CALC_PW    = $clog2(CALC_PORTS);
    localparam int CALC_DW    = 32;
    localparam int CALC_SHW   = $clog2(CALC_DW);

    localparam logic [3:0] OP_ADD = 4'h1;
    localparam logic [3:0] OP_SUB = 4'h2;
    localparam logic [3:0] OP_SHL = 4'h5;
    localparam logic [3:0] OP_SHR = 4'h6;

    localparam logic [1:0] RC_NONE = 2'b00;
    localparam logic [1:0] RC_OK   = 2'b01;
    localparam logic [1:0] RC_OVF  = 2'b10;
    localparam logic [1:0] RC_BAD  = 2'b11;

    typedef struct packed {
        logic [CALC_PW-1:0] port;
        logic [1:0]         tag;
        logic [3:0]         op;
        logic [CALC_DW-1:0] a;
        logic [CALC_DW-1:0] b;
    } calc_req_t;

    typedef struct packed {
        logic [CALC_PW-1:0] port;
        logic [1:0]         tag;
        logic [1:0]         code;
        logic [CALC_DW-1:0] data;
    } calc_rsp_t;

    // Shift opcodes go to the shift queue; everything else to arithmetic.
    function automatic logic calc_is_shift(logic [3:0] op);
        return (op == OP_SHL) || (op == OP_SHR);
    endfunction

    // Add/subtract with carry and borrow detection; unknown ops are invalid.
    function automatic calc_rsp_t calc_arith(calc_req_t r);
        calc_rsp_t        o;
        logic [CALC_DW:0] s;
        s      = '0;
        o.port = r.port;
        o.tag  = r.tag;
        o.code = RC_BAD;
        o.data = '0;
        case (r.op)
            OP_ADD: begin
                s      = {1'b0, r.a} + {1'b0, r.b};
                o.data = s[CALC_DW-1:0];
                o.code = s[CALC_DW] ? RC_OVF : RC_OK;
            end
            OP_SUB: begin
                o.data = r.a - r.b;
                o.code = (r.b > r.a) ? RC_OVF : RC_OK;
            end
            default: ;
        endcase
        return o;
    endfunction

    // Logical shifts by the low bits of operand b.
    function automatic calc_rsp_t calc_shift(calc_req_t r);
        calc_rsp_t o;
        o.port = r.port;
        o.tag  = r.tag;
        o.code = RC_BAD;
        o.data = '0;
        case (r.op)
            OP_SHL: begin
                o.data = r.a << r.b[CALC_SHW-1:0];
                o.code = RC_OK;
            end
            OP_SHR: begin
                o.data = r.a >> r.b[CALC_SHW-1:0];
                o.code = RC_OK;
            end
            default: ;
        endcase
        return o;
    endfunction
endpackage

// File: rtl/calc_rr_arb.sv
// Round-robin arbiter: grants one requester per cycle while en is high,
// searching from the port after the last winner. Assumes N >= 2.
module calc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         en,
    output logic [N-1:0] grant
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic [IW-1:0] gidx;
    logic [IW-1:0] idx;
    logic          found;

    // Pick the first request at or after the rotating pointer.
    always_comb begin
        grant = '0;
        gidx  = ptr;
        idx   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = IW'((int'(ptr) + k) % N);
            if (en && !found && req[idx]) begin
                grant[idx] = 1'b1;
                gidx       = idx;
                found      = 1'b1;
            end
        end
    end

    // Move the pointer past the winner after every grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
        end
    end
endmodule

// File: rtl/calc_fifo.sv
// Synchronous FIFO holding queued commands. The caller never pushes
// when full nor pops when empty.
module calc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;

    assign full  = (cnt == (AW+1)'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = mem[rp];

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/calc_exec.sv
// Execution pipeline of LAT stages. KIND 0 computes add/subtract,
// KIND 1 computes shifts. The whole pipe stalls when its last stage holds
// a result that the merge logic has not taken; order is preserved.
module calc_exec
    import calc_pkg::*;
#(
    parameter int KIND = 0,
    parameter int LAT  = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  calc_req_t in_req,
    output logic      in_pop,
    output logic      out_valid,
    output calc_rsp_t out_rsp,
    input  logic      out_take
);
    logic [LAT-1:0] stv;
    calc_rsp_t      st [LAT];
    calc_rsp_t      res;
    logic           advance;

    generate
        if (KIND == 0) begin : g_arith
            assign res = calc_arith(in_req);
        end else begin : g_shift
            assign res = calc_shift(in_req);
        end
    endgenerate

    assign advance   = !stv[LAT-1] || out_take;
    assign in_pop    = in_valid && advance;
    assign out_valid = stv[LAT-1];
    assign out_rsp   = st[LAT-1];

    // Entry stage takes the queue head whenever the pipe moves.
    always_ff @(posedge clk) begin
        if (!rst_n) stv[0] <= 1'b0;
        else if (advance) stv[0] <= in_pop;
    end

    // Entry stage data.
    always_ff @(posedge clk) begin
        if (advance) st[0] <= res;
    end

    genvar i;
    generate
        for (i = 1; i < LAT; i++) begin : g_stage
            // Later stages copy their predecessor when the pipe moves.
            always_ff @(posedge clk) begin
                if (!rst_n) stv[i] <= 1'b0;
                else if (advance) stv[i] <= stv[i-1];
            end
            // Stage data follows its valid bit.
            always_ff @(posedge clk) begin
                if (advance) st[i] <= st[i-1];
            end
        end
    endgenerate
endmodule

// File: rtl/calc_tagged_hub.sv
// Four-port tagged calculator. Ports present commands with a 2-bit tag;
// a busy-tag table stalls reuse of an outstanding tag. Two arbiters feed an
// arithmetic and a shift queue, each drained by its own pipeline. A merge
// stage returns results to the issuing port, giving the arithmetic result
// precedence on a same-port collision and the held shift result the next
// cycle. Assumes the host holds a command stable until cmd_ready.
module calc_tagged_hub
    import calc_pkg::*;
#(
    parameter int QDEPTH    = 4,
    parameter int ARITH_LAT = 1,
    parameter int SHIFT_LAT = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [CALC_PORTS-1:0]                cmd_valid,
    input  logic [CALC_PORTS-1:0][3:0]           cmd_op,
    input  logic [CALC_PORTS-1:0][1:0]           cmd_tag,
    input  logic [CALC_PORTS-1:0][CALC_DW-1:0]   cmd_a,
    input  logic [CALC_PORTS-1:0][CALC_DW-1:0]   cmd_b,
    output logic [CALC_PORTS-1:0]                cmd_ready,
    output logic [CALC_PORTS-1:0]                rsp_valid,
    output logic [CALC_PORTS-1:0][1:0]           rsp_code,
    output logic [CALC_PORTS-1:0][1:0]           rsp_tag,
    output logic [CALC_PORTS-1:0][CALC_DW-1:0]   rsp_data
);
    localparam int NP   = CALC_PORTS;
    localparam int PW   = CALC_PW;
    localparam int REQW = $bits(calc_req_t);

    logic [NP-1:0][3:0] tag_busy;
    logic [NP-1:0]      want_ar;
    logic [NP-1:0]      want_sh;
    logic [NP-1:0]      ar_grant;
    logic [NP-1:0]      sh_grant;

    logic      ar_full, sh_full, ar_empty, sh_empty;
    logic      ar_pop, sh_pop;
    calc_req_t ar_in, sh_in;
    logic [REQW-1:0] ar_head_raw, sh_head_raw;
    calc_req_t ar_head, sh_head;

    logic      ar_v, sh_v, ar_take, sh_take, same_port, sh_held;
    calc_rsp_t ar_o, sh_o;

    // Classify each port's command and mask ports whose tag is busy.
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            want_ar[p] = cmd_valid[p] && !tag_busy[p][cmd_tag[p]] && !calc_is_shift(cmd_op[p]);
            want_sh[p] = cmd_valid[p] && !tag_busy[p][cmd_tag[p]] &&  calc_is_shift(cmd_op[p]);
        end
    end

    calc_rr_arb #(.N(NP)) u_ar_arb (
        .clk(clk), .rst_n(rst_n), .req(want_ar), .en(!ar_full), .grant(ar_grant)
    );
    calc_rr_arb #(.N(NP)) u_sh_arb (
        .clk(clk), .rst_n(rst_n), .req(want_sh), .en(!sh_full), .grant(sh_grant)
    );

    assign cmd_ready = ar_grant | sh_grant;

    // Build the queue entries from the granted ports.
    always_comb begin
        ar_in = '0;
        sh_in = '0;
        for (int p = 0; p < NP; p++) begin
            if (ar_grant[p]) ar_in = '{port: PW'(p), tag: cmd_tag[p], op: cmd_op[p], a: cmd_a[p], b: cmd_b[p]};
            if (sh_grant[p]) sh_in = '{port: PW'(p), tag: cmd_tag[p], op: cmd_op[p], a: cmd_a[p], b: cmd_b[p]};
        end
    end

    calc_fifo #(.W(REQW), .DEPTH(QDEPTH)) u_ar_q (
        .clk(clk), .rst_n(rst_n), .push(|ar_grant), .din(ar_in), .full(ar_full),
        .pop(ar_pop), .dout(ar_head_raw), .empty(ar_empty)
    );
    calc_fifo #(.W(REQW), .DEPTH(QDEPTH)) u_sh_q (
        .clk(clk), .rst_n(rst_n), .push(|sh_grant), .din(sh_in), .full(sh_full),
        .pop(sh_pop), .dout(sh_head_raw), .empty(sh_empty)
    );

    assign ar_head = calc_req_t'(ar_head_raw);
    assign sh_head = calc_req_t'(sh_head_raw);

    calc_exec #(.KIND(0), .LAT(ARITH_LAT)) u_ar_exe (
        .clk(clk), .rst_n(rst_n), .in_valid(!ar_empty), .in_req(ar_head), .in_pop(ar_pop),
        .out_valid(ar_v), .out_rsp(ar_o), .out_take(ar_take)
    );
    calc_exec #(.KIND(1), .LAT(SHIFT_LAT)) u_sh_exe (
        .clk(clk), .rst_n(rst_n), .in_valid(!sh_empty), .in_req(sh_head), .in_pop(sh_pop),
        .out_valid(sh_v), .out_rsp(sh_o), .out_take(sh_take)
    );

    // Collision rule: arithmetic first, a held shift wins on the next cycle.
    assign same_port = ar_v && sh_v && (ar_o.port == sh_o.port);
    assign ar_take   = ar_v && !(same_port && sh_held);
    assign sh_take   = sh_v && !(same_port && !sh_held);

    // Remember that the shift result was held back this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_held <= 1'b0;
        else        sh_held <= sh_v && !sh_take;
    end

    // Register each port's response from whichever pipeline delivers to it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_code  <= '0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (ar_take && ar_o.port == PW'(p)) begin
                    rsp_valid[p] <= 1'b1;
                    rsp_code[p]  <= ar_o.code;
                    rsp_tag[p]   <= ar_o.tag;
                    rsp_data[p]  <= ar_o.data;
                end else if (sh_take && sh_o.port == PW'(p)) begin
                    rsp_valid[p] <= 1'b1;
                    rsp_code[p]  <= sh_o.code;
                    rsp_tag[p]   <= sh_o.tag;
                    rsp_data[p]  <= sh_o.data;
                end else begin
                    rsp_valid[p] <= 1'b0;
                end
            end
        end
    end

    // Mark tags busy on acceptance and free them on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_busy <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                for (int t = 0; t < 4; t++) begin
                    if (cmd_ready[p] && cmd_tag[p] == 2'(t))
                        tag_busy[p][t] <= 1'b1;
                    else if ((ar_take && ar_o.port == PW'(p) && ar_o.tag == 2'(t)) ||
                             (sh_take && sh_o.port == PW'(p) && sh_o.tag == 2'(t)))
                        tag_busy[p][t] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/calc_hub_checker.sv
// Port-level protocol checks for the tagged calculator. Keeps its own
// record of tags issued per port from the command handshake.
module calc_hub_checker
    import calc_pkg::*;
(
    input logic                               clk,
    input logic                               rst_n,
    input logic [CALC_PORTS-1:0]              cmd_valid,
    input logic [CALC_PORTS-1:0][3:0]         cmd_op,
    input logic [CALC_PORTS-1:0][1:0]         cmd_tag,
    input logic [CALC_PORTS-1:0]              cmd_ready,
    input logic [CALC_PORTS-1:0]              rsp_valid,
    input logic [CALC_PORTS-1:0][1:0]         rsp_code,
    input logic [CALC_PORTS-1:0][1:0]         rsp_tag
);
    logic [CALC_PORTS-1:0][3:0] issued;
    logic [CALC_PORTS-1:0]      ar_acc;

    // Track outstanding tags as seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued <= '0;
        end else begin
            for (int p = 0; p < CALC_PORTS; p++) begin
                for (int t = 0; t < 4; t++) begin
                    if (cmd_valid[p] && cmd_ready[p] && cmd_tag[p] == 2'(t))
                        issued[p][t] <= 1'b1;
                    else if (rsp_valid[p] && rsp_tag[p] == 2'(t))
                        issued[p][t] <= 1'b0;
                end
            end
        end
    end

    // Arithmetic-class acceptances this cycle.
    always_comb begin
        for (int p = 0; p < CALC_PORTS; p++)
            ar_acc[p] = cmd_valid[p] && cmd_ready[p] && !calc_is_shift(cmd_op[p]);
    end

    AST_ARITH_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ar_acc) <= 1); // R9

    genvar g;
    generate
        for (g = 0; g < CALC_PORTS; g++) begin : g_port
            AST_RSP_TAG_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid[g] |-> issued[g][rsp_tag[g]]); // R6
            AST_BUSY_TAG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_valid[g] && issued[g][cmd_tag[g]] &&
                 !(rsp_valid[g] && rsp_tag[g] == cmd_tag[g])) |-> !cmd_ready[g]); // R7
            AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_ready[g] |-> cmd_valid[g]); // R7
            AST_RSP_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid[g] |-> rsp_code[g] != RC_NONE); // R5
        end
    endgenerate
endmodule

bind calc_tagged_hub calc_hub_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tag(cmd_tag), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_tag(rsp_tag)
);

// File: tb/sim_calc_tagged_hub.sv
`timescale 1ns/1ps
module sim_calc_tagged_hub;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [3:0]        cmd_valid;
    logic [3:0][3:0]   cmd_op;
    logic [3:0][1:0]   cmd_tag;
    logic [3:0][31:0]  cmd_a;
    logic [3:0][31:0]  cmd_b;
    logic [3:0]        cmd_ready;
    logic [3:0]        rsp_valid;
    logic [3:0][1:0]   rsp_code;
    logic [3:0][1:0]   rsp_tag;
    logic [3:0][31:0]  rsp_data;

    calc_tagged_hub u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tag(cmd_tag), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_ready(cmd_ready),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    int    nchk = 0;
    int    nerr = 0;
    int    cyc  = 0;
    bit    pending [4][4];
    logic [1:0]  ecode [4][4];
    logic [31:0] edata [4][4];
    string ereq  [4][4];
    int    arr   [4][4];
    int    ord   [4][8];
    int    ocnt  [4];
    int    acc   [4];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference results written from the requirements.
    task automatic model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         output logic [1:0] c, output logic [31:0] d);
        logic [32:0] s;
        c = 2'b11; d = 32'h0;
        case (op)
            4'h1: begin s = {1'b0, a} + {1'b0, b}; d = s[31:0]; c = s[32] ? 2'b10 : 2'b01; end
            4'h2: begin d = a - b; c = (b > a) ? 2'b10 : 2'b01; end
            4'h5: begin d = a << b[4:0]; c = 2'b01; end
            4'h6: begin d = a >> b[4:0]; c = 2'b01; end
            default: ;
        endcase
    endtask

    // Response monitor: compares each response with what was issued (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 4; p++) begin
                if (rsp_valid[p]) begin
                    int t;
                    t = int'(rsp_tag[p]);
                    if (!pending[p][t]) begin
                        chk(1'b0, "R6", $sformatf("stray response port %0d tag", p), 64'(t), 64'hFFFF);
                    end else begin
                        chk(rsp_code[p] == ecode[p][t] && rsp_data[p] == edata[p][t], ereq[p][t],
                            $sformatf("port %0d tag %0d code/data", p, t),
                            {30'h0, rsp_code[p], rsp_data[p]}, {30'h0, ecode[p][t], edata[p][t]});
                        pending[p][t] = 1'b0;
                        arr[p][t] = cyc;
                        if (ocnt[p] < 8) ord[p][ocnt[p]] = t;
                        ocnt[p]++;
                    end
                end
            end
        end
    end

    // Present one command on port p and hold it until accepted.
    task automatic issue(int p, logic [3:0] op, logic [1:0] tag, logic [31:0] a,
                         logic [31:0] b, string req, output int tries);
        bit ok;
        @(negedge clk);
        cmd_valid[p] = 1'b1; cmd_op[p] = op; cmd_tag[p] = tag; cmd_a[p] = a; cmd_b[p] = b;
        tries = 0;
        do begin
            #2;
            tries++;
            ok = cmd_ready[p];
            if (!ok) @(negedge clk);
        end while (!ok && tries < 200);
        chk(ok && !pending[p][tag], "R7", $sformatf("accept port %0d tag %0d while free", p, tag),
            64'(pending[p][tag]), 64'h0);
        acc[p] = cyc;
        model(op, a, b, ecode[p][tag], edata[p][tag]);
        ereq[p][tag] = req;
        pending[p][tag] = 1'b1;
        @(posedge clk);
        #1 cmd_valid[p] = 1'b0;
    endtask

    task automatic wait_idle();
        bit busy;
        for (int i = 0; i < 300; i++) begin
            busy = 1'b0;
            for (int p = 0; p < 4; p++)
                for (int t = 0; t < 4; t++)
                    if (pending[p][t]) busy = 1'b1;
            if (!busy) return;
            @(negedge clk);
        end
        chk(1'b0, "R6", "responses missing after timeout", 64'h1, 64'h0);
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        chk(rsp_valid == 4'h0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
        issue(0, 4'h1, 2'd0, 32'd5, 32'd7, "R2", n);
        chk(n == 1, "R1", "first-cycle acceptance tries", 64'(n), 64'h1);
        wait_idle();
    endtask

    task automatic t_add();
        int n;
        issue(0, 4'h1, 2'd0, 32'hFFFFFFFF, 32'h1, "R2", n);
        issue(0, 4'h1, 2'd1, 32'hFFFFFFFE, 32'h1, "R2", n);
        issue(0, 4'h1, 2'd2, 32'h7FFFFFFF, 32'h80000000, "R2", n);
        issue(0, 4'h1, 2'd3, 32'h80000000, 32'h80000000, "R2", n);
        wait_idle();
        issue(1, 4'h1, 2'd0, 32'h12345678, 32'h11111111, "R2", n);
        wait_idle();
    endtask

    task automatic t_sub();
        int n;
        issue(1, 4'h2, 2'd0, 32'd10, 32'd3, "R3", n);
        issue(1, 4'h2, 2'd1, 32'd5, 32'd5, "R3", n);
        issue(1, 4'h2, 2'd2, 32'd5, 32'd6, "R3", n);
        issue(1, 4'h2, 2'd3, 32'h0, 32'h1, "R3", n);
        wait_idle();
    endtask

    task automatic t_shift();
        int n;
        issue(2, 4'h5, 2'd0, 32'hA5A5A5A5, 32'd0, "R4", n);
        issue(2, 4'h5, 2'd1, 32'h1, 32'd31, "R4", n);
        issue(2, 4'h6, 2'd2, 32'h80000000, 32'd31, "R4", n);
        issue(2, 4'h6, 2'd3, 32'hF0, 32'h21, "R4", n);
        wait_idle();
    endtask

    task automatic t_bad();
        int n;
        issue(3, 4'h0, 2'd0, 32'd1, 32'd2, "R5", n);
        issue(3, 4'h1, 2'd1, 32'd1, 32'd2, "R5", n);
        issue(3, 4'h3, 2'd2, 32'd9, 32'd9, "R5", n);
        issue(3, 4'hF, 2'd3, 32'd9, 32'd9, "R5", n);
        wait_idle();
    endtask

    task automatic t_ports();
        fork
            begin int n; issue(0, 4'h1, 2'd2, 32'd100, 32'd1, "R6", n); issue(0, 4'h5, 2'd3, 32'd3, 32'd4, "R6", n); end
            begin int n; issue(1, 4'h6, 2'd1, 32'h100, 32'd4, "R6", n); issue(1, 4'h2, 2'd0, 32'd9, 32'd4, "R6", n); end
            begin int n; issue(2, 4'h2, 2'd3, 32'd1, 32'd2, "R6", n); issue(2, 4'h5, 2'd0, 32'd1, 32'd8, "R6", n); end
            begin int n; issue(3, 4'h7, 2'd1, 32'd1, 32'd1, "R6", n); issue(3, 4'h1, 2'd2, 32'd6, 32'd6, "R6", n); end
        join
        wait_idle();
    endtask

    task automatic t_tagstall();
        int n;
        for (int t = 0; t < 4; t++) begin
            issue(2, 4'h5, 2'(t), 32'(t + 1), 32'd1, "R7", n);
            chk(n == 1, "R7", $sformatf("back-to-back accept tag %0d tries", t), 64'(n), 64'h1);
        end
        wait_idle();
        issue(0, 4'h1, 2'd0, 32'd1, 32'd1, "R7", n);
        issue(0, 4'h1, 2'd0, 32'd2, 32'd2, "R7", n);
        chk(n >= 2, "R7", "busy tag held before acceptance, tries", 64'(n), 64'h2);
        wait_idle();
    endtask

    task automatic t_order();
        for (int p = 0; p < 4; p++) ocnt[p] = 0;
        fork
            begin int n; for (int t = 0; t < 4; t++) issue(1, 4'h1, 2'(t), 32'(t), 32'd1, "R8", n); end
            begin int n; for (int t = 0; t < 4; t++) issue(0, 4'h2, 2'(3 - t), 32'd50, 32'(t), "R8", n); end
        join
        wait_idle();
        for (int k = 0; k < 4; k++) begin
            chk(ord[1][k] == k, "R8", $sformatf("port 1 arrival %0d tag", k), 64'(ord[1][k]), 64'(k));
            chk(ord[0][k] == 3 - k, "R8", $sformatf("port 0 arrival %0d tag", k), 64'(ord[0][k]), 64'(3 - k));
        end
    endtask

    task automatic t_rr();
        int lo, hi;
        bit distinct;
        fork
            begin int n; issue(0, 4'h1, 2'd1, 32'd1, 32'd1, "R9", n); end
            begin int n; issue(1, 4'h1, 2'd1, 32'd2, 32'd1, "R9", n); end
            begin int n; issue(2, 4'h1, 2'd1, 32'd3, 32'd1, "R9", n); end
            begin int n; issue(3, 4'h1, 2'd1, 32'd4, 32'd1, "R9", n); end
        join
        wait_idle();
        lo = acc[0]; hi = acc[0]; distinct = 1'b1;
        for (int p = 0; p < 4; p++) begin
            if (acc[p] < lo) lo = acc[p];
            if (acc[p] > hi) hi = acc[p];
            for (int q = p + 1; q < 4; q++) if (acc[p] == acc[q]) distinct = 1'b0;
        end
        chk(distinct, "R9", "one arithmetic grant per cycle", 64'(distinct), 64'h1);
        chk(hi - lo == 3, "R9", "grant span in cycles", 64'(hi - lo), 64'h3);
    endtask

    task automatic t_conflict();
        int n1, n2;
        issue(3, 4'h5, 2'd0, 32'h3, 32'd2, "R10", n1);
        issue(3, 4'h1, 2'd1, 32'h3, 32'd2, "R10", n2);
        chk(n1 == 1 && n2 == 1, "R10", "back-to-back setup tries", 64'(n1 + n2), 64'h2);
        wait_idle();
        chk(arr[3][0] == arr[3][1] + 1, "R10", "shift arrival minus add arrival",
            64'(arr[3][0] - arr[3][1]), 64'h1);
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_valid = '0; cmd_op = '0; cmd_tag = '0; cmd_a = '0; cmd_b = '0;
        for (int p = 0; p < 4; p++) begin
            ocnt[p] = 0; acc[p] = 0;
            for (int t = 0; t < 4; t++) begin pending[p][t] = 1'b0; arr[p][t] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_shift();
        t_bad();
        t_ports();
        t_tagstall();
        t_order();
        t_rr();
        t_conflict();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #800000;
        nchk++;
        nerr++;
        $display("FAIL R6 watchdog expired: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule